// File: doc/BRIEF.md
# Flash command status and launch register

This block is the 8-bit status register that sits in front of a non-volatile memory command engine. Software starts a command by writing a one to the command-complete bit. That bit then drops, and the block sends the engine a launch strobe one clock wide. The engine's completion, error and verify-result inputs set the register bits again. Software clears the error flags by writing ones to them.

An access error or a protection violation blocks every launch until software clears it. A command that is still busy also blocks a launch. A second path lets the emulated-EEPROM logic hold the command-complete bit low from a successful RAM-window write until its record has been written. The completion interrupt is the command-complete bit gated by an enable input.

Top module: `fcmd_status`

## Requirements
- R1: After reset all eight bits read as zero, and `launch` and `irq` are low. The bit layout is: 7 = command complete, 6 = read collision, 5 = access error, 4 = protection violation, 3..1 = reserved, 0 = command result.
- R2: A write with a one in bit 6, 5 or 4 clears that flag. A write with a zero in those positions leaves the flag unchanged.
- R3: Bits 3..1 always read zero, whatever value is written to them.
- R4: Bit 0 loads `eng_result` in each cycle where `eng_done` is high. Bus writes never change bit 0.
- R5: A write with bit 7 set launches a command when bit 7 is one and bits 5 and 4 are zero. At the clock edge of that write, bit 7 clears and `launch` goes high for exactly one cycle. Bit 7 then stays low until the engine ends the command.
- R6: While bit 5 or bit 4 is set, a write with bit 7 set is ignored. Bit 7 keeps its value and `launch` stays low. This holds even when the same write clears the error flag.
- R7: A write with bit 7 set while bit 7 is zero (busy) produces no launch.
- R8: An `eng_acc_err` or `eng_prot_viol` pulse sets bit 5 or bit 4 respectively. The same edge sets bit 7, which ends the command.
- R9: When a hardware set and a write-one-to-clear hit the same error flag in the same cycle, the flag ends up set.
- R10: An `ee_write_ok` pulse clears bit 7. Bit 7 stays low until `ee_record_done` is asserted, and is set on that edge.
- R11: `irq` equals bit 7 AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| eng_done | input | 1 | Engine reports command completion |
| eng_result | input | 1 | Command result, sampled with eng_done |
| eng_rdcol | input | 1 | Engine reports a read collision |
| eng_acc_err | input | 1 | Engine rejects a command for an access error |
| eng_prot_viol | input | 1 | Engine rejects a command for a protection violation |
| ee_write_ok | input | 1 | Successful write to the emulated-EEPROM RAM window |
| ee_record_done | input | 1 | Emulated-EEPROM record creation finished |
| irq_en | input | 1 | Completion interrupt enable |
| launch | output | 1 | One-cycle command launch strobe |
| irq | output | 1 | Completion interrupt |

## Verification
Two things can land on the same error flag in one cycle: the engine setting it and software clearing it with write-one-to-clear. The bench drives both in the same cycle, for the read-collision flag and for the access-error flag, and expects the flag to read back as set. A launch write and the clearing of a blocking error can also fall in the same cycle, through one write that carries both bit 7 and the error bit. The bench expects the error to clear with no launch strobe and with bit 7 unchanged.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_DONE  = 7;
  localparam int ERR_LSB   = 4;
  localparam int NUM_ERR   = 3;
  localparam int IDX_PVIOL = 0;
  localparam int IDX_ACC   = 1;
  localparam int IDX_RDCOL = 2;
  localparam int BIT_RES   = 0;

  typedef struct packed {
    logic                done;
    logic [NUM_ERR-1:0]  err;
    logic                result;
  } status_t;

  function automatic logic [REG_W-1:0] pack_status(input status_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_DONE] = s.done;
    v[ERR_LSB +: NUM_ERR] = s.err;
    v[BIT_RES] = s.result;
    return v;
  endfunction

  function automatic logic launch_allowed(input logic done_q,
                                          input logic [NUM_ERR-1:0] err);
    return done_q && !err[IDX_ACC] && !err[IDX_PVIOL];
  endfunction
endpackage

// File: rtl/fcs_flag_cell.sv
module fcs_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (hw_set) q <= 1'b1;
    else if (sw_clr) q <= 1'b0;
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr && !hw_set |=> !q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);
endmodule

// File: rtl/fcs_launch_ctrl.sv
module fcs_launch_ctrl
  import fcs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_launch,
  input  logic               done_q,
  input  logic [NUM_ERR-1:0] err_q,
  output logic               launch_req,
  output logic               launch
);
  assign launch_req = wr_launch && launch_allowed(done_q, err_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) launch <= 1'b0;
    else        launch <= launch_req;
  end

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
  assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(!err_q[IDX_ACC] && !err_q[IDX_PVIOL]));
  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(done_q));
endmodule

// File: rtl/fcs_done_track.sv
module fcs_done_track (
  input  logic clk,
  input  logic rst_n,
  input  logic end_evt,
  input  logic launch_req,
  input  logic ee_hold,
  output logic done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     done_q <= 1'b0;
    else if (end_evt)               done_q <= 1'b1;
    else if (launch_req || ee_hold) done_q <= 1'b0;
  end

  assert_end_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> done_q);
  assert_ee_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ee_hold && !end_evt |=> !done_q);
  assert_stays_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q && !end_evt |=> !done_q);
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             eng_done,
  input  logic             eng_result,
  input  logic             eng_rdcol,
  input  logic             eng_acc_err,
  input  logic             eng_prot_viol,
  input  logic             ee_write_ok,
  input  logic             ee_record_done,
  input  logic             irq_en,
  output logic             launch,
  output logic             irq
);
  logic [NUM_ERR-1:0] err_set;
  logic [NUM_ERR-1:0] err_q;
  logic               done_q;
  logic               result_q;
  logic               launch_req;
  logic               end_evt;
  logic               wr_launch;
  status_t            st;

  assign err_set[IDX_PVIOL] = eng_prot_viol;
  assign err_set[IDX_ACC]   = eng_acc_err;
  assign err_set[IDX_RDCOL] = eng_rdcol;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    fcs_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (err_set[i]),
      .sw_clr (wr_en && wr_data[ERR_LSB+i]),
      .q      (err_q[i])
    );
  end

  assign wr_launch = wr_en && wr_data[BIT_DONE];
  assign end_evt   = eng_done || eng_acc_err || eng_prot_viol || ee_record_done;

  fcs_launch_ctrl u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_launch  (wr_launch),
    .done_q     (done_q),
    .err_q      (err_q),
    .launch_req (launch_req),
    .launch     (launch)
  );

  fcs_done_track u_done (
    .clk        (clk),
    .rst_n      (rst_n),
    .end_evt    (end_evt),
    .launch_req (launch_req),
    .ee_hold    (ee_write_ok),
    .done_q     (done_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= 1'b0;
    else if (eng_done) result_q <= eng_result;
  end

  assign st.done   = done_q;
  assign st.err    = err_q;
  assign st.result = result_q;
  assign rd_data   = pack_status(st);
  assign irq       = done_q && irq_en;

  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_data[3:1] != 3'b000) |=> rd_data[3:1] == 3'b000);
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_done && wr_en && (wr_data[BIT_RES] != rd_data[BIT_RES]) |=> $stable(rd_data[BIT_RES]));
  assert_err_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_acc_err |=> rd_data[BIT_DONE] && rd_data[ERR_LSB+IDX_ACC]);
  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_data[BIT_DONE]);
endmodule

// File: tb/fcmd_status_bench.sv
`timescale 1ns/1ps
module fcmd_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic eng_done = 0, eng_result = 0, eng_rdcol = 0, eng_acc_err = 0, eng_prot_viol = 0;
  logic ee_write_ok = 0, ee_record_done = 0, irq_en = 0;
  logic launch, irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fcmd_status u_fcmd_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .eng_done(eng_done), .eng_result(eng_result), .eng_rdcol(eng_rdcol),
    .eng_acc_err(eng_acc_err), .eng_prot_viol(eng_prot_viol),
    .ee_write_ok(ee_write_ok), .ee_record_done(ee_record_done),
    .irq_en(irq_en), .launch(launch), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive for one clock edge, then release; returns at a falling edge.
  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_cmd(input logic res);
    @(negedge clk); eng_done = 1; eng_result = res;
    @(negedge clk); eng_done = 0; eng_result = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset value", rd_data, 8'h00);
    chk("R1 reset launch", {7'd0, launch}, 8'd0);
    chk("R1 reset irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_result_and_reserved;
    finish_cmd(1'b1);
    chk("R4 result loaded", rd_data, 8'h81);
    write(8'h0E);
    chk("R3 reserved ignored", rd_data, 8'h81);
    write(8'h00);
    chk("R4 write zero to result", rd_data, 8'h81);
    finish_cmd(1'b0);
    chk("R4 result reloaded", rd_data, 8'h80);
    write(8'h01);
    chk("R4 write one to result", rd_data, 8'h80);
  endtask

  task automatic t_launch_and_busy;
    write(8'h80);
    chk("R5 launch pulse", {7'd0, launch}, 8'd1);
    chk("R5 done cleared", rd_data, 8'h00);
    @(negedge clk);
    chk("R5 pulse one cycle", {7'd0, launch}, 8'd0);
    idle(3);
    chk("R5 stays low", rd_data, 8'h00);
    write(8'h80);
    chk("R7 busy launch", {7'd0, launch}, 8'd0);
    irq_en = 1;
    @(negedge clk);
    chk("R11 irq while busy", {7'd0, irq}, 8'd0);
    finish_cmd(1'b1);
    chk("R5 completed", rd_data, 8'h81);
    chk("R11 irq set", {7'd0, irq}, 8'd1);
    irq_en = 0;
    @(negedge clk);
    chk("R11 irq masked", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_errors;
    write(8'h80);
    @(negedge clk); eng_acc_err = 1;
    @(negedge clk); eng_acc_err = 0;
    chk("R8 access error ends", rd_data, 8'hA1);
    write(8'h00);
    chk("R2 zero write keeps", rd_data, 8'hA1);
    write(8'h80);
    chk("R6 blocked by access error", {7'd0, launch}, 8'd0);
    chk("R6 done kept", rd_data, 8'hA1);
    write(8'h20);
    chk("R2 access error cleared", rd_data, 8'h81);
    write(8'h80);
    @(negedge clk); eng_prot_viol = 1;
    @(negedge clk); eng_prot_viol = 0;
    chk("R8 protection ends", rd_data, 8'h91);
    write(8'h90);
    chk("R6 clear and launch same write", {7'd0, launch}, 8'd0);
    chk("R6 only flag cleared", rd_data, 8'h81);
  endtask

  task automatic t_collision;
    @(negedge clk); eng_rdcol = 1;
    @(negedge clk); eng_rdcol = 0;
    chk("R2 read collision set", rd_data, 8'hC1);
    write(8'h40);
    chk("R2 read collision cleared", rd_data, 8'h81);
    @(negedge clk); eng_rdcol = 1; wr_en = 1; wr_data = 8'h40;
    @(negedge clk); eng_rdcol = 0; wr_en = 0; wr_data = 8'h00;
    chk("R9 collision set wins", rd_data, 8'hC1);
    @(negedge clk); eng_acc_err = 1; wr_en = 1; wr_data = 8'h20;
    @(negedge clk); eng_acc_err = 0; wr_en = 0; wr_data = 8'h00;
    chk("R9 access set wins", rd_data, 8'hE1);
    write(8'h60);
    chk("R2 both cleared", rd_data, 8'h81);
  endtask

  task automatic t_eeprom;
    @(negedge clk); ee_write_ok = 1;
    @(negedge clk); ee_write_ok = 0;
    chk("R10 done held low", rd_data, 8'h01);
    idle(4);
    chk("R10 still low", rd_data, 8'h01);
    @(negedge clk); ee_record_done = 1;
    @(negedge clk); ee_record_done = 0;
    chk("R10 released", rd_data, 8'h81);
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(2);
    t_reset;
    @(negedge clk); rst_n = 1;
    idle(1);
    t_result_and_reserved;
    t_launch_and_busy;
    t_errors;
    t_collision;
    t_eeprom;
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule